// File: doc/BRIEF.md
# Host-Strobed Parallel FIFO Port

This block is a parallel data port that an external host drives. The host supplies one line that acts as both clock and chip select (the strobe) and a second line that gives the transfer direction. On each strobe rising edge the host either takes the next word from a local transmit FIFO or hands one word to a local receive FIFO. Local software or a DMA engine fills the transmit FIFO and drains the receive FIFO through valid/ready handshakes.

Both host lines cross into the local clock through two-flop synchronizers. A rising-edge detector then turns each strobe edge into a one-cycle event, so the strobe period must be at least four local clock cycles. A read-request output tells the host when transmit data is waiting, and the host can use it as an interrupt. The host has no flow control on writes. A write that arrives while the receive FIFO is full is dropped and sets a sticky overflow interrupt. Two mode bits enable the port. With any other setting the port is silent.

Top module: `strobe_fifo_port`

## Requirements
- R1: The port is active only when `mode_sel`=1 and `clk_out_sel`=0. With any other setting, `host_oe` and `rd_req` are 0 and strobe edges change neither FIFO.
- R2: Each strobe rising edge causes exactly one transfer, however long the strobe stays high. The transfer takes effect on the third local clock edge after the strobe rises.
- R3: When `host_dir`=1 at a strobe edge, the oldest transmit word is driven on `host_dout` and `host_oe` goes to 1.
- R4: In active mode, `rd_req` is 1 while the transmit FIFO holds data. It goes to 0 one local cycle after the edge event that reads the last word.
- R5: A host read with an empty transmit FIFO pops nothing: the level stays 0, and the next word pushed is the next word read.
- R6: When `host_dir`=0 at a strobe edge, `host_din` is pushed into the receive FIFO if there is space, and `host_oe` returns to 0.
- R7: A host write into a full receive FIFO is discarded, the stored contents are unchanged, and `ovf_irq` is set and stays set.
- R8: A one-cycle pulse on `ovf_clr` clears `ovf_irq`.
- R9: Both FIFOs are first-in first-out, with 16 entries of 16 bits each. `tx_wready` = not full and `rx_rvalid` = not empty. The full, empty and level (0..16) outputs track occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 1 | Port-enable mode bit |
| clk_out_sel | input | 1 | Local-strobe mode bit; must be 0 for the external-strobe mode |
| host_stb | input | 1 | Host clock/chip-select strobe |
| host_dir | input | 1 | Host direction, 1 = host reads |
| host_din | input | 16 | Data bus from the host |
| host_dout | output | 16 | Data bus to the host |
| host_oe | output | 1 | Tri-state enable for `host_dout` |
| rd_req | output | 1 | Transmit data is waiting (host interrupt) |
| ovf_irq | output | 1 | Sticky receive overflow interrupt |
| ovf_clr | input | 1 | Write-one-to-clear pulse for `ovf_irq` |
| tx_wvalid | input | 1 | Local push request into the transmit FIFO |
| tx_wready | output | 1 | Transmit FIFO can accept a word |
| tx_wdata | input | 16 | Local push data |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_level | output | 5 | Transmit FIFO occupancy |
| rx_rvalid | output | 1 | Receive FIFO holds a word |
| rx_rready | input | 1 | Local pop of the receive FIFO |
| rx_rdata | output | 16 | Oldest receive word |
| rx_full | output | 1 | Receive FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_level | output | 5 | Receive FIFO occupancy |

## Verification
The bench reads from an empty transmit FIFO and then checks that the next pushed word comes out intact. A design that pops on empty would return stale data or wrap its level. It checks `rd_req` in the cycle before and the cycle after the last read, so a request that drops early or late shows up. It also writes a seventeenth word into a full receive FIFO and drains all sixteen entries in order: a design that overwrites data or loses the flag fails here. Finally it holds the strobe high for many cycles and toggles the mode bits, which exposes level-triggered transfers and a port that wakes in the wrong mode.

// File: rtl/strobe_fifo_port.sv
module strobe_fifo_port #(
  parameter int DW    = 16,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_sel,
  input  logic          clk_out_sel,
  input  logic          host_stb,
  input  logic          host_dir,
  input  logic [DW-1:0] host_din,
  output logic [DW-1:0] host_dout,
  output logic          host_oe,
  output logic          rd_req,
  output logic          ovf_irq,
  input  logic          ovf_clr,
  input  logic          tx_wvalid,
  output logic          tx_wready,
  input  logic [DW-1:0] tx_wdata,
  output logic          tx_full,
  output logic          tx_empty,
  output logic [$clog2(DEPTH):0] tx_level,
  output logic          rx_rvalid,
  input  logic          rx_rready,
  output logic [DW-1:0] rx_rdata,
  output logic          rx_full,
  output logic          rx_empty,
  output logic [$clog2(DEPTH):0] rx_level
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic          ext_mode;
  logic [2:0]    stb_sy;
  logic [1:0]    dir_sy;
  logic          edge_ev, rd_ev, wr_ev;
  logic          oe_q;

  logic [DW-1:0] tx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp;
  logic [AW:0]   tx_cnt;
  logic          tx_push, tx_pop;

  logic [DW-1:0] rx_mem [DEPTH];
  logic [AW-1:0] rx_wp, rx_rp;
  logic [AW:0]   rx_cnt;
  logic          rx_push, rx_pop;

  assign ext_mode = mode_sel & ~clk_out_sel;
  assign edge_ev  = ext_mode & stb_sy[1] & ~stb_sy[2];
  assign rd_ev    = edge_ev & dir_sy[1];
  assign wr_ev    = edge_ev & ~dir_sy[1];

  assign tx_full   = (tx_cnt == FULL_CNT);
  assign tx_empty  = (tx_cnt == '0);
  assign tx_level  = tx_cnt;
  assign tx_wready = ~tx_full;
  assign tx_push   = tx_wvalid & ~tx_full;
  assign tx_pop    = rd_ev & ~tx_empty;

  assign rx_full   = (rx_cnt == FULL_CNT);
  assign rx_empty  = (rx_cnt == '0);
  assign rx_level  = rx_cnt;
  assign rx_rvalid = ~rx_empty;
  assign rx_rdata  = rx_mem[rx_rp];
  assign rx_push   = wr_ev & ~rx_full;
  assign rx_pop    = rx_rready & ~rx_empty;

  assign rd_req  = ext_mode & ~tx_empty;
  assign host_oe = ext_mode & oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_sy <= '0;
      dir_sy <= '0;
    end else begin
      stb_sy <= {stb_sy[1:0], host_stb};
      dir_sy <= {dir_sy[0], host_dir};
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= tx_wdata;
    if (rx_push) rx_mem[rx_wp] <= host_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0;
      tx_rp <= '0;
      tx_cnt <= '0;
      rx_wp <= '0;
      rx_rp <= '0;
      rx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      if (tx_push && !tx_pop) tx_cnt <= tx_cnt + 1'b1;
      else if (tx_pop && !tx_push) tx_cnt <= tx_cnt - 1'b1;
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      if (rx_push && !rx_pop) rx_cnt <= rx_cnt + 1'b1;
      else if (rx_pop && !rx_push) rx_cnt <= rx_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_dout <= '0;
      oe_q      <= 1'b0;
      ovf_irq   <= 1'b0;
    end else begin
      if (tx_pop) host_dout <= tx_mem[tx_rp];
      if (!ext_mode)  oe_q <= 1'b0;
      else if (rd_ev) oe_q <= 1'b1;
      else if (wr_ev) oe_q <= 1'b0;
      if (wr_ev && rx_full) ovf_irq <= 1'b1;
      else if (ovf_clr)     ovf_irq <= 1'b0;
    end
  end
endmodule

// File: rtl/strobe_fifo_port_chk.sv
module strobe_fifo_port_chk #(
  parameter int DW    = 16,
  parameter int DEPTH = 16
) (
  input logic clk,
  input logic rst_n,
  input logic mode_sel,
  input logic clk_out_sel,
  input logic host_oe,
  input logic rd_req,
  input logic ovf_irq,
  input logic ovf_clr,
  input logic tx_wvalid,
  input logic tx_wready,
  input logic tx_full,
  input logic tx_empty,
  input logic rx_full,
  input logic rx_rready,
  input logic [$clog2(DEPTH):0] rx_level
);
  localparam int AW = $clog2(DEPTH);
  localparam int WUNUSED = DW;

  AST_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode_sel && !clk_out_sel) |-> (!host_oe && !rd_req)); // R1
  AST_RDREQ_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !tx_empty); // R4
  AST_EMPTY_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && !tx_wvalid) |=> tx_empty); // R5
  AST_RX_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !rx_rready) |=> rx_full); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_irq && !ovf_clr) |=> ovf_irq); // R7
  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_irq && ovf_clr && !rx_full) |=> !ovf_irq); // R8
  AST_TX_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |-> !tx_wready); // R9
  AST_RX_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= (AW+1)'(DEPTH)); // R9
endmodule

bind strobe_fifo_port strobe_fifo_port_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .clk_out_sel(clk_out_sel),
  .host_oe(host_oe), .rd_req(rd_req), .ovf_irq(ovf_irq), .ovf_clr(ovf_clr),
  .tx_wvalid(tx_wvalid), .tx_wready(tx_wready), .tx_full(tx_full),
  .tx_empty(tx_empty), .rx_full(rx_full), .rx_rready(rx_rready),
  .rx_level(rx_level)
);

// File: tb/sim_strobe_fifo_port.sv
`timescale 1ns/1ps
module sim_strobe_fifo_port;
  logic clk = 0, rst_n = 0;
  logic mode_sel = 0, clk_out_sel = 0, host_stb = 0, host_dir = 0;
  logic [15:0] host_din = 0, host_dout, tx_wdata = 0, rx_rdata;
  logic host_oe, rd_req, ovf_irq, ovf_clr = 0;
  logic tx_wvalid = 0, tx_wready, tx_full, tx_empty;
  logic rx_rvalid, rx_rready = 0, rx_full, rx_empty;
  logic [4:0] tx_level, rx_level;
  int n_cmp = 0, n_bad = 0;
  logic [15:0] tx_q[$];
  logic [15:0] rx_q[$];

  always #2.5 clk = ~clk;

  strobe_fifo_port u0 (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tx_push(input logic [15:0] d);
    tx_wdata = d; tx_wvalid = 1;
    @(negedge clk); tx_wvalid = 0;
    tx_q.push_back(d);
  endtask

  task automatic stb_rise(input logic dir, input logic [15:0] d, input int hold);
    host_dir = dir; host_din = d; host_stb = 1;
    repeat (hold) @(negedge clk);
  endtask

  task automatic stb_fall();
    host_stb = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic host_read(input bit last);
    logic [15:0] e;
    e = tx_q.pop_front();
    host_dir = 1; host_stb = 1;
    repeat (2) @(negedge clk);
    if (last) chk(rd_req == 1, "R4 rd_req before last read", rd_req, 1);
    @(negedge clk);
    chk(host_dout == e, "R3 read data", host_dout, e);
    chk(host_oe == 1, "R3 output enable", host_oe, 1);
    if (last) chk(rd_req == 0, "R4 rd_req after last read", rd_req, 0);
    stb_fall();
  endtask

  task automatic host_write(input logic [15:0] d, input bit expect_room);
    stb_rise(0, d, 3);
    if (expect_room) rx_q.push_back(d);
    stb_fall();
  endtask

  task automatic rx_pop();
    logic [15:0] e;
    e = rx_q.pop_front();
    chk(rx_rvalid == 1, "R9 rx_rvalid", rx_rvalid, 1);
    chk(rx_rdata == e, "R6 receive data order", rx_rdata, e);
    rx_rready = 1;
    @(negedge clk); rx_rready = 0;
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!host_oe && !rd_req && !ovf_irq, "R9 reset outputs", {host_oe, rd_req, ovf_irq}, 0);
    chk(tx_empty && rx_empty && tx_level == 0 && rx_level == 0, "R9 reset levels", tx_level, 0);

    // R1: inactive mode
    tx_push(16'h1111); tx_push(16'h2222);
    chk(rd_req == 0, "R1 rd_req in off mode", rd_req, 0);
    stb_rise(1, 0, 3);
    chk(host_oe == 0 && tx_level == 2, "R1 read ignored", tx_level, 2);
    stb_fall();
    stb_rise(0, 16'hDEAD, 3);
    chk(rx_level == 0, "R1 write ignored", rx_level, 0);
    stb_fall();
    mode_sel = 1; clk_out_sel = 1;
    @(negedge clk);
    chk(rd_req == 0, "R1 rd_req with clock-out set", rd_req, 0);
    clk_out_sel = 0;
    @(negedge clk);
    chk(rd_req == 1, "R4 rd_req with data", rd_req, 1);

    host_read(0);
    host_read(1);

    // R5: empty read
    stb_rise(1, 0, 3);
    chk(tx_level == 0 && tx_empty, "R5 empty read no pop", tx_level, 0);
    stb_fall();
    tx_push(16'hBEEF);
    host_read(1);

    // R2: long strobe high gives one transfer
    tx_push(16'h0A0A); tx_push(16'h0B0B);
    stb_rise(1, 0, 12);
    chk(tx_level == 1, "R2 one transfer per edge", tx_level, 1);
    chk(host_dout == tx_q[0], "R2 data of single transfer", host_dout, tx_q[0]);
    void'(tx_q.pop_front());
    stb_fall();

    // R6: write drops output enable
    host_write(16'h5A00, 1);
    chk(host_oe == 0, "R6 oe low after write", host_oe, 0);
    for (int i = 1; i < 16; i++) host_write(16'h5A00 + 16'(i), 1);
    chk(rx_full && rx_level == 16, "R9 rx full at 16", rx_level, 16);
    chk(ovf_irq == 0, "R7 no overflow yet", ovf_irq, 0);
    host_write(16'hFFFF, 0);
    chk(ovf_irq == 1, "R7 overflow flag", ovf_irq, 1);
    chk(rx_level == 16, "R7 overflow word dropped", rx_level, 16);
    for (int i = 0; i < 16; i++) rx_pop();
    chk(rx_empty, "R7 only stored words drain", rx_level, 0);
    chk(ovf_irq == 1, "R7 overflow sticky", ovf_irq, 1);
    ovf_clr = 1; @(negedge clk); ovf_clr = 0;
    chk(ovf_irq == 0, "R8 overflow cleared", ovf_irq, 0);

    // R9: transmit fill
    for (int i = 0; i < 15; i++) tx_push(16'hC000 + 16'(i));
    chk(tx_full && !tx_wready && tx_level == 16, "R9 tx full backpressure", tx_level, 16);
    tx_wdata = 16'hEEEE; tx_wvalid = 1; @(negedge clk); tx_wvalid = 0;
    chk(tx_level == 16, "R9 push into full ignored", tx_level, 16);
    for (int i = 0; i < 16; i++) host_read(i == 15);
    chk(tx_empty, "R9 tx drained", tx_level, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule